// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides which of a set of interrupt sources is served next. Every source holds a pending flag, an enable bit, a four-bit priority level and a two-bit group level. Each cycle, the arbiter looks at the pending and enabled sources whose level is above the current CPU priority. It picks the one with the highest level and breaks ties on the group level. It then registers a grant that names the winning source and states how the request is to be served.

Requests at the two top levels are routed to a per-source transfer channel while that channel still has a non-zero transfer count. All other requests take the normal CPU interrupt entry. When the grant is acknowledged, the block updates the source flag, the transfer count and the CPU priority. A separate return input loads a saved priority back into the CPU level when a service routine ends.

Configuration, flag writes and count loads arrive through simple indexed write ports. Equal level and group settings among competing sources are a configuration fault. The arbiter resolves such a tie by taking the lowest index, and it records the fault in a sticky flag.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, all flags, enables, levels, groups and counts are 0, the CPU level is 0, no grant is valid and the conflict flag is 0.
- R2: A one-cycle pulse on a source's event input sets its pending flag at that clock edge. The flag is visible on `flags_o` at bit position equal to the source index.
- R3: A software flag write sets or clears the addressed flag exactly as hardware would. A set raises a request and a clear withdraws one. When an event, an acknowledge and a software write hit the same flag in one cycle, the software write decides the flag.
- R4: A source whose enable bit is 0 never wins, whatever its flag and level. Setting the enable bit lets a pending source compete.
- R5: Among eligible sources, the one with the numerically largest four-bit level wins.
- R6: Among eligible sources that share the winning level, the one with the numerically largest two-bit group level wins.
- R7: A source is eligible only when its level is strictly greater than the current CPU level, so a level-0 source is never granted.
- R8: A grant becomes valid one clock edge after an eligible pending source is present. Its index, route and level stay fixed until `ack_i` is seen. The grant is invalid in the cycle that follows the acknowledge.
- R9: A grant is routed to the transfer channel (`gnt_xfer_o`=1) only when its level is 14 or 15 (binary 111x) and the source's transfer count is non-zero. Every other grant, including levels 1 to 13, takes the CPU route (`gnt_xfer_o`=0).
- R10: Acknowledging a CPU-route grant clears the source's flag and loads the grant level into the CPU level.
- R11: Acknowledging a transfer-route grant decrements the source's count and leaves the CPU level unchanged. It clears the flag, unless the count reaches zero, in which case the flag stays set so that a CPU-route grant follows.
- R12: A pulse on `ret_i` loads `ret_lvl_i` into the CPU level. A CPU-route acknowledge in the same cycle takes precedence.
- R13: When two or more eligible sources share the winning level and group, the lowest index wins and `conflict_o` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | Per-source hardware event pulses |
| cfg_we_i | input | 1 | Write strobe for one source's configuration |
| cfg_idx_i | input | IDX_W | Source addressed by the configuration write |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_lvl_i | input | 4 | Priority level to write |
| cfg_grp_i | input | 2 | Group level to write |
| flag_we_i | input | 1 | Software flag write strobe |
| flag_idx_i | input | IDX_W | Source addressed by the flag write |
| flag_val_i | input | 1 | Flag value to write |
| cnt_we_i | input | 1 | Transfer count load strobe |
| cnt_idx_i | input | IDX_W | Source addressed by the count load |
| cnt_val_i | input | CNT_W | Transfer count to load |
| ack_i | input | 1 | Acknowledge of the current grant |
| ret_i | input | 1 | Service return: restore CPU level |
| ret_lvl_i | input | 4 | Saved CPU level to restore |
| flags_o | output | N_SRC | Pending flag of every source |
| cpu_lvl_o | output | 4 | Current CPU priority level |
| gnt_valid_o | output | 1 | A grant is being offered |
| gnt_idx_o | output | IDX_W | Index of the granted source |
| gnt_xfer_o | output | 1 | 1 = transfer channel, 0 = CPU interrupt entry |
| gnt_lvl_o | output | 4 | Level of the granted source |
| conflict_o | output | 1 | Sticky flag for an equal level and group tie |

## Verification
The bench builds the arbiter with eight sources and a four-bit transfer count. Eight sources are enough to set a level-and-group tie, a disabled source, a level-0 source and two top-level transfer sources side by side. The small count lets a channel load of 2 run down to zero in two services, so the hand-over from the transfer route to the CPU route with the flag still set is reached within a few dozen cycles. The return input is used to restore arbitrary levels, including 15, so that the strict level comparison and flag withdrawal can be probed with the CPU level held above every source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 4;
    localparam int GRP_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [GRP_W-1:0] grp_t;

    typedef struct packed {
        logic en;
        lvl_t lvl;
        grp_t grp;
    } src_cfg_t;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int CNT_W = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       evt_i,
    input  logic                   cfg_we_i,
    input  logic [IDX_W-1:0]       cfg_idx_i,
    input  src_cfg_t               cfg_i,
    input  logic                   flag_we_i,
    input  logic [IDX_W-1:0]       flag_idx_i,
    input  logic                   flag_val_i,
    input  logic                   cnt_we_i,
    input  logic [IDX_W-1:0]       cnt_idx_i,
    input  logic [CNT_W-1:0]       cnt_val_i,
    input  logic                   ack_i,
    input  logic [IDX_W-1:0]       ack_idx_i,
    input  logic                   ack_xfer_i,
    output logic [N_SRC-1:0]       flags_o,
    output src_cfg_t [N_SRC-1:0]   cfg_o,
    output logic [N_SRC-1:0]       cnt_zero_o
);

    typedef struct packed {
        logic             flag;
        src_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
    } src_state_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        src_state_t st_d, st_q;
        logic       hit_ack, hit_flag, hit_cfg, hit_cnt;

        assign hit_ack  = ack_i     && (ack_idx_i  == IDX_W'(gi));
        assign hit_flag = flag_we_i && (flag_idx_i == IDX_W'(gi));
        assign hit_cfg  = cfg_we_i  && (cfg_idx_i  == IDX_W'(gi));
        assign hit_cnt  = cnt_we_i  && (cnt_idx_i  == IDX_W'(gi));

        always_comb begin
            st_d = st_q;
            // service acknowledge: lowest precedence on the flag
            if (hit_ack) begin
                if (ack_xfer_i) begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - CNT_ONE;
                    end
                    // last transfer keeps the request alive for the CPU
                    st_d.flag = (st_q.cnt == CNT_ONE);
                end else begin
                    st_d.flag = 1'b0;
                end
            end
            if (evt_i[gi]) begin
                st_d.flag = 1'b1;
            end
            if (hit_flag) begin
                st_d.flag = flag_val_i;
            end
            if (hit_cfg) begin
                st_d.cfg = cfg_i;
            end
            if (hit_cnt) begin
                st_d.cnt = cnt_val_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign flags_o[gi]    = st_q.flag;
        assign cfg_o[gi]      = st_q.cfg;
        assign cnt_zero_o[gi] = (st_q.cnt == '0);

        // R11: final transfer of a channel leaves the request pending
        assert_flag_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_ack && ack_xfer_i && st_q.cnt == CNT_ONE && !hit_flag)
            |=> st_q.flag);

        // R3: software write decides the flag over event and acknowledge
        assert_sw_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hit_flag |=> (st_q.flag == $past(flag_val_i)));
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       flags_i,
    input  src_cfg_t [N_SRC-1:0]   cfg_i,
    input  lvl_t                   cpu_lvl_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       idx_o,
    output lvl_t                   lvl_o,
    output logic                   conflict_o
);

    localparam int KEY_W = LVL_W + GRP_W;

    logic [N_SRC-1:0] cand;
    logic [KEY_W-1:0] best_key;
    logic             seen, dup;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            cand[i] = flags_i[i] && cfg_i[i].en && (cfg_i[i].lvl > cpu_lvl_i);
        end
    end

    // linear scan: strictly greater replaces, so the lowest index keeps a tie
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        best_key = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!found_o || {cfg_i[i].lvl, cfg_i[i].grp} > best_key)) begin
                found_o  = 1'b1;
                idx_o    = IDX_W'(i);
                best_key = {cfg_i[i].lvl, cfg_i[i].grp};
            end
        end
        lvl_o = best_key[KEY_W-1 -: LVL_W];
    end

    always_comb begin
        seen = 1'b0;
        dup  = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && ({cfg_i[i].lvl, cfg_i[i].grp} == best_key)) begin
                dup  = dup | seen;
                seen = 1'b1;
            end
        end
        conflict_o = found_o && dup;
    end

    // R7: a winner always lies above the CPU level
    always_comb begin
        if (found_o) begin
            assert_pick_above_R7: assert (lvl_o > cpu_lvl_i);
        end
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   evt_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic               cfg_en_i,
    input  logic [3:0]         cfg_lvl_i,
    input  logic [1:0]         cfg_grp_i,
    input  logic               flag_we_i,
    input  logic [IDX_W-1:0]   flag_idx_i,
    input  logic               flag_val_i,
    input  logic               cnt_we_i,
    input  logic [IDX_W-1:0]   cnt_idx_i,
    input  logic [CNT_W-1:0]   cnt_val_i,
    input  logic               ack_i,
    input  logic               ret_i,
    input  logic [3:0]         ret_lvl_i,
    output logic [N_SRC-1:0]   flags_o,
    output logic [3:0]         cpu_lvl_o,
    output logic               gnt_valid_o,
    output logic [IDX_W-1:0]   gnt_idx_o,
    output logic               gnt_xfer_o,
    output logic [3:0]         gnt_lvl_o,
    output logic               conflict_o
);

    typedef struct packed {
        logic             gnt_v;
        logic [IDX_W-1:0] gnt_idx;
        logic             gnt_xfer;
        lvl_t             gnt_lvl;
        lvl_t             cpu_lvl;
        logic             conflict;
    } arb_state_t;

    arb_state_t st_d, st_q;

    src_cfg_t               wr_cfg;
    src_cfg_t [N_SRC-1:0]   src_cfg;
    logic [N_SRC-1:0]       src_flags;
    logic [N_SRC-1:0]       cnt_zero;
    logic                   ack_fire;
    logic                   pick_found, pick_conflict;
    logic [IDX_W-1:0]       pick_idx;
    lvl_t                   pick_lvl;

    assign wr_cfg   = '{en: cfg_en_i, lvl: cfg_lvl_i, grp: cfg_grp_i};
    assign ack_fire = ack_i && st_q.gnt_v;

    irq_src_bank #(
        .N_SRC (N_SRC),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_idx_i  (cfg_idx_i),
        .cfg_i      (wr_cfg),
        .flag_we_i  (flag_we_i),
        .flag_idx_i (flag_idx_i),
        .flag_val_i (flag_val_i),
        .cnt_we_i   (cnt_we_i),
        .cnt_idx_i  (cnt_idx_i),
        .cnt_val_i  (cnt_val_i),
        .ack_i      (ack_fire),
        .ack_idx_i  (st_q.gnt_idx),
        .ack_xfer_i (st_q.gnt_xfer),
        .flags_o    (src_flags),
        .cfg_o      (src_cfg),
        .cnt_zero_o (cnt_zero)
    );

    irq_pick #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) i_pick (
        .flags_i    (src_flags),
        .cfg_i      (src_cfg),
        .cpu_lvl_i  (st_q.cpu_lvl),
        .found_o    (pick_found),
        .idx_o      (pick_idx),
        .lvl_o      (pick_lvl),
        .conflict_o (pick_conflict)
    );

    always_comb begin
        st_d = st_q;
        if (ret_i) begin
            st_d.cpu_lvl = ret_lvl_i;
        end
        if (ack_fire) begin
            st_d.gnt_v = 1'b0;
            if (!st_q.gnt_xfer) begin
                st_d.cpu_lvl = st_q.gnt_lvl;
            end
        end
        // arbitrate only while no grant is outstanding
        if (!st_q.gnt_v && pick_found) begin
            st_d.gnt_v    = 1'b1;
            st_d.gnt_idx  = pick_idx;
            st_d.gnt_lvl  = pick_lvl;
            st_d.gnt_xfer = (pick_lvl[LVL_W-1:1] == '1) && !cnt_zero[pick_idx];
            st_d.conflict = st_q.conflict | pick_conflict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o     = src_flags;
    assign cpu_lvl_o   = st_q.cpu_lvl;
    assign gnt_valid_o = st_q.gnt_v;
    assign gnt_idx_o   = st_q.gnt_idx;
    assign gnt_xfer_o  = st_q.gnt_xfer;
    assign gnt_lvl_o   = st_q.gnt_lvl;
    assign conflict_o  = st_q.conflict;

    assert_grant_above_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid_o) |-> (gnt_lvl_o > $past(cpu_lvl_o)));

    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && !ack_i) |=> (gnt_valid_o && $stable(gnt_idx_o)
                                     && $stable(gnt_xfer_o) && $stable(gnt_lvl_o)));

    assert_grant_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && ack_i) |=> !gnt_valid_o);

    assert_xfer_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && gnt_xfer_o) |-> (gnt_lvl_o[3:1] == 3'b111));

    assert_cpu_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid_o && ack_i && !gnt_xfer_o) |=> (cpu_lvl_o == $past(gnt_lvl_o)));

    assert_ret_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !(gnt_valid_o && ack_i && !gnt_xfer_o)) |=> (cpu_lvl_o == $past(ret_lvl_i)));

    assert_conflict_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |=> conflict_o);

endmodule

// File: tb/test_prio_irq_arbiter.sv
`timescale 1ns/1ps
module test_prio_irq_arbiter;

    localparam int N_SRC = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(N_SRC);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_SRC-1:0]   evt_i = '0;
    logic               cfg_we_i = 1'b0;
    logic [IDX_W-1:0]   cfg_idx_i = '0;
    logic               cfg_en_i = 1'b0;
    logic [3:0]         cfg_lvl_i = '0;
    logic [1:0]         cfg_grp_i = '0;
    logic               flag_we_i = 1'b0;
    logic [IDX_W-1:0]   flag_idx_i = '0;
    logic               flag_val_i = 1'b0;
    logic               cnt_we_i = 1'b0;
    logic [IDX_W-1:0]   cnt_idx_i = '0;
    logic [CNT_W-1:0]   cnt_val_i = '0;
    logic               ack_i = 1'b0;
    logic               ret_i = 1'b0;
    logic [3:0]         ret_lvl_i = '0;
    logic [N_SRC-1:0]   flags_o;
    logic [3:0]         cpu_lvl_o;
    logic               gnt_valid_o;
    logic [IDX_W-1:0]   gnt_idx_o;
    logic               gnt_xfer_o;
    logic [3:0]         gnt_lvl_o;
    logic               conflict_o;

    prio_irq_arbiter #(.N_SRC(N_SRC), .CNT_W(CNT_W)) i_prio_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_en_i(cfg_en_i),
        .cfg_lvl_i(cfg_lvl_i), .cfg_grp_i(cfg_grp_i),
        .flag_we_i(flag_we_i), .flag_idx_i(flag_idx_i), .flag_val_i(flag_val_i),
        .cnt_we_i(cnt_we_i), .cnt_idx_i(cnt_idx_i), .cnt_val_i(cnt_val_i),
        .ack_i(ack_i), .ret_i(ret_i), .ret_lvl_i(ret_lvl_i),
        .flags_o(flags_o), .cpu_lvl_o(cpu_lvl_o), .gnt_valid_o(gnt_valid_o),
        .gnt_idx_o(gnt_idx_o), .gnt_xfer_o(gnt_xfer_o), .gnt_lvl_o(gnt_lvl_o),
        .conflict_o(conflict_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    idx;
        int    xfer;
        int    lvl;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    bit   prev_v = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: every new grant is compared with the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (gnt_valid_o && !prev_v) begin
                if (exp_q.size() == 0) begin
                    chk("unexpected grant idx", int'(gnt_idx_o), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " grant idx"},   int'(gnt_idx_o),  e.idx);
                    chk({e.req, " grant route"}, int'(gnt_xfer_o), e.xfer);
                    chk({e.req, " grant level"}, int'(gnt_lvl_o),  e.lvl);
                end
            end
            prev_v = gnt_valid_o;
        end
    end

    task automatic expect_gnt(input int idx, input int xfer, input int lvl, input string req);
        exp_t e;
        e.idx = idx; e.xfer = xfer; e.lvl = lvl; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic cfg(input int idx, input bit en, input int lvl, input int grp);
        cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_en_i = en;
        cfg_lvl_i = 4'(lvl); cfg_grp_i = 2'(grp);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic set_cnt(input int idx, input int v);
        cnt_we_i = 1'b1; cnt_idx_i = IDX_W'(idx); cnt_val_i = CNT_W'(v);
        @(negedge clk);
        cnt_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [N_SRC-1:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic flag_wr(input int idx, input bit v);
        flag_we_i = 1'b1; flag_idx_i = IDX_W'(idx); flag_val_i = v;
        @(negedge clk);
        flag_we_i = 1'b0;
    endtask

    task automatic ack_it();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic ret_to(input int l);
        ret_i = 1'b1; ret_lvl_i = 4'(l);
        @(negedge clk);
        ret_i = 1'b0;
    endtask

    task automatic wait_gnt(input string req);
        for (int i = 0; i < 10; i++) begin
            if (gnt_valid_o) break;
            @(negedge clk);
        end
        chk({req, " grant arrives"}, int'(gnt_valid_o), 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 cpu level", int'(cpu_lvl_o), 0);
        chk("R1 grant valid", int'(gnt_valid_o), 0);
        chk("R1 conflict", int'(conflict_o), 0);
        chk("R1 flags", int'(flags_o), 0);

        // R5/R6 level then group, R4 disabled source ignored
        cfg(2, 1, 5, 1);
        cfg(5, 1, 5, 2);
        cfg(1, 1, 3, 3);
        cfg(7, 0, 9, 0);
        expect_gnt(5, 0, 5, "R6");
        pulse(8'hA6);
        chk("R2 flags after events", int'(flags_o), 'hA6);
        wait_gnt("R6");
        idle(3);
        chk("R8 grant held valid", int'(gnt_valid_o), 1);
        chk("R8 grant held idx", int'(gnt_idx_o), 5);
        ack_it();
        chk("R8 grant drops after ack", int'(gnt_valid_o), 0);
        chk("R10 cpu level loaded", int'(cpu_lvl_o), 5);
        chk("R10 flag cleared", int'(flags_o[5]), 0);
        idle(4);
        chk("R7 equal level not taken", int'(gnt_valid_o), 0);

        // R12 return, then R5 higher level wins
        expect_gnt(2, 0, 5, "R5");
        ret_to(0);
        chk("R12 cpu level restored", int'(cpu_lvl_o), 0);
        wait_gnt("R5");
        ack_it();
        expect_gnt(1, 0, 3, "R5");
        ret_to(0);
        wait_gnt("R5 low");
        ack_it();
        chk("R10 cpu level 3", int'(cpu_lvl_o), 3);
        ret_to(0);
        idle(3);
        chk("R4 disabled pending not granted", int'(gnt_valid_o), 0);
        expect_gnt(7, 0, 9, "R4");
        cfg(7, 1, 9, 0);
        wait_gnt("R4 enabled");
        ack_it();
        ret_to(0);

        // R7 level 0 never granted
        cfg(3, 1, 0, 0);
        pulse(8'h08);
        idle(3);
        chk("R7 level0 flag pending", int'(flags_o[3]), 1);
        chk("R7 level0 no grant", int'(gnt_valid_o), 0);

        // R9/R11 transfer route and hand-over
        set_cnt(4, 2);
        cfg(4, 1, 14, 0);
        expect_gnt(4, 1, 14, "R9");
        pulse(8'h10);
        wait_gnt("R9 xfer");
        ack_it();
        chk("R11 flag cleared count 1", int'(flags_o[4]), 0);
        chk("R11 cpu level unchanged", int'(cpu_lvl_o), 0);
        expect_gnt(4, 1, 14, "R9");
        pulse(8'h10);
        wait_gnt("R9 xfer2");
        expect_gnt(4, 0, 14, "R11");
        ack_it();
        chk("R11 flag kept at zero count", int'(flags_o[4]), 1);
        wait_gnt("R11 follow-up");
        ack_it();
        chk("R10 cpu level 14", int'(cpu_lvl_o), 14);
        chk("R10 flag cleared", int'(flags_o[4]), 0);
        ret_to(0);
        set_cnt(6, 3);
        cfg(6, 1, 13, 0);
        expect_gnt(6, 0, 13, "R9");
        pulse(8'h40);
        wait_gnt("R9 level13");
        ack_it();
        ret_to(0);

        // R3 software flag writes
        expect_gnt(6, 0, 13, "R3");
        flag_wr(6, 1'b1);
        chk("R3 sw set flag", int'(flags_o[6]), 1);
        wait_gnt("R3 sw");
        ack_it();
        ret_to(0);
        evt_i = 8'h40;
        flag_wr(6, 1'b0);
        evt_i = '0;
        chk("R3 sw clear beats event", int'(flags_o[6]), 0);
        idle(3);
        chk("R3 no grant after clear", int'(gnt_valid_o), 0);
        ret_to(15);
        pulse(8'h40);
        chk("R3 event pending", int'(flags_o[6]), 1);
        flag_wr(6, 1'b0);
        chk("R3 sw withdraw", int'(flags_o[6]), 0);
        ret_to(0);
        idle(3);
        chk("R3 withdrawn not granted", int'(gnt_valid_o), 0);

        // R13 conflict tie
        cfg(0, 1, 8, 1);
        cfg(6, 1, 8, 1);
        expect_gnt(0, 0, 8, "R13");
        pulse(8'h41);
        wait_gnt("R13");
        chk("R13 conflict raised", int'(conflict_o), 1);
        expect_gnt(6, 0, 8, "R13");
        ack_it();
        ret_to(0);
        wait_gnt("R13 second");
        ack_it();
        ret_to(0);
        idle(3);
        chk("R13 conflict sticky", int'(conflict_o), 1);

        idle(3);
        chk("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule